// File: doc/BRIEF.md
# Packet Timestamp Capture Latch

This block freezes the running 64-bit time into a single-entry holding register when a packet event qualifies for timestamping. Two identical capture paths live inside it, one for received packets and one for transmitted packets. Each path has its own class-enable field, its own rule and parameter exclusion masks, and its own holding register with a valid flag and a sequence tag.

Packet parsing happens upstream. For every event the parser presents a one-cycle strobe, a class code, a 14-bit vector of rule hits, an 11-bit vector of parameter hits and a 16-bit sequence tag. Once a path has captured a timestamp it locks: further events are dropped until software reads the low and high words and writes the status word with the valid bit set to rearm the path. The time value comes from an external time generator.

Top module: `ts_capture_latch`

## Requirements
- R1: After reset, both paths read valid 0, sequence 0, timestamp 0, class enable 0, rule mask 0x3FFF and parameter mask 0x7FF.
- R2: The register address is 4 bits. Bit 3 selects the path (0 receive, 1 transmit) and bits 2:0 select the register: 0 status, 1 timestamp bits 31:0, 2 timestamp bits 63:32, 3 class enable (bits 2:0), 4 rule mask (bits 13:0), 5 parameter mask (bits 10:0). Offsets 6 and 7 read zero, writes to offsets 1, 2, 6 and 7 change nothing, and unused bits read zero.
- R3: An event that qualifies while the path's valid flag is clear sets valid on the next clock, loads the timestamp with the time input present in the event cycle and loads the sequence with the event's sequence tag.
- R4: An event qualifies only if at least one rule-hit bit whose mask bit is 0 is set and at least one parameter-hit bit whose mask bit is 0 is set; a set mask bit excludes that rule or parameter, so all-ones masks block every event.
- R5: Class codes 0, 1 and 2 are enabled by enable bits 0, 1 and 2; class code 3 never qualifies; an enable value of 0 blocks every event.
- R6: While valid is set, events are ignored and the held timestamp and sequence do not change.
- R7: A status write with bit 16 set clears valid on the next clock; a status write with bit 16 clear has no effect; timestamp and sequence keep their values until the next capture.
- R8: When a rearming status write and a qualifying event fall in the same cycle while valid is set, valid clears and the event is dropped; a rearming write while valid is already clear does not stop a qualifying event in that cycle from being captured.
- R9: The two paths are independent: events, configuration and rearming on one path never change the other path's registers.
- R10: The status word reads valid in bit 16 and the sequence in bits 15:0, with bits 31:17 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| time_i | input | 64 | Current time from the time generator |
| rx_evt_i | input | 1 | Receive event strobe, one cycle per packet |
| rx_class_i | input | 2 | Receive event class code |
| rx_rule_hit_i | input | 14 | Receive rule hit vector |
| rx_param_hit_i | input | 11 | Receive parameter hit vector |
| rx_seq_i | input | 16 | Receive sequence tag |
| tx_evt_i | input | 1 | Transmit event strobe, one cycle per packet |
| tx_class_i | input | 2 | Transmit event class code |
| tx_rule_hit_i | input | 14 | Transmit rule hit vector |
| tx_param_hit_i | input | 11 | Transmit parameter hit vector |
| tx_seq_i | input | 16 | Transmit sequence tag |
| reg_we_i | input | 1 | Register write enable |
| reg_waddr_i | input | 4 | Register write address |
| reg_wdata_i | input | 32 | Register write data |
| reg_raddr_i | input | 4 | Register read address |
| reg_rdata_o | output | 32 | Register read data, combinational on the read address |

## Verification
The collision that matters is a rearming status write landing in the same cycle as a qualifying event. The bench provokes it on purpose with valid set, where the event must be lost and the path must read clear afterwards, and with valid already clear, where the event must still be captured; the random phase then overlaps writes, mask changes and events on both paths at high rates. A behavioural model predicts every register each clock, and one register per clock is read back and compared, sweeping all sixteen addresses.

// File: rtl/ts_latch_pkg.sv
package ts_latch_pkg;
  localparam int TS_W      = 64;
  localparam int WORD_W    = 32;
  localparam int RULE_W    = 14;
  localparam int PARAM_W   = 11;
  localparam int CLASS_N   = 3;
  localparam int CLS_W     = $clog2(CLASS_N + 1);
  localparam int SEQ_W     = 16;
  localparam int VALID_BIT = SEQ_W;
  localparam int DIR_N     = 2;
  localparam int ADDR_W    = 4;
  localparam int OFF_W     = 3;

  localparam logic [OFF_W-1:0] OFF_STATUS = 3'd0;
  localparam logic [OFF_W-1:0] OFF_TS_LO  = 3'd1;
  localparam logic [OFF_W-1:0] OFF_TS_HI  = 3'd2;
  localparam logic [OFF_W-1:0] OFF_EN     = 3'd3;
  localparam logic [OFF_W-1:0] OFF_RMASK  = 3'd4;
  localparam logic [OFF_W-1:0] OFF_PMASK  = 3'd5;
endpackage

// File: rtl/ts_cfg_regs.sv
module ts_cfg_regs #(
  parameter int CLASS_N = 3,
  parameter int RULE_W  = 14,
  parameter int PARAM_W = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_en_i,
  input  logic               we_rmask_i,
  input  logic               we_pmask_i,
  input  logic [CLASS_N-1:0] en_d_i,
  input  logic [RULE_W-1:0]  rmask_d_i,
  input  logic [PARAM_W-1:0] pmask_d_i,
  output logic [CLASS_N-1:0] en_o,
  output logic [RULE_W-1:0]  rmask_o,
  output logic [PARAM_W-1:0] pmask_o
);
  // masks reset to all ones: nothing qualifies until configured
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o    <= '0;
      rmask_o <= '1;
      pmask_o <= '1;
    end else begin
      if (we_en_i)    en_o    <= en_d_i;
      if (we_rmask_i) rmask_o <= rmask_d_i;
      if (we_pmask_i) pmask_o <= pmask_d_i;
    end
  end
endmodule

// File: rtl/ts_qualify.sv
module ts_qualify #(
  parameter int CLASS_N = 3,
  parameter int CLS_W   = 2,
  parameter int RULE_W  = 14,
  parameter int PARAM_W = 11
) (
  input  logic               evt_i,
  input  logic [CLS_W-1:0]   class_i,
  input  logic [RULE_W-1:0]  rule_hit_i,
  input  logic [PARAM_W-1:0] param_hit_i,
  input  logic [CLASS_N-1:0] en_i,
  input  logic [RULE_W-1:0]  rmask_i,
  input  logic [PARAM_W-1:0] pmask_i,
  output logic               qual_o
);
  logic cls_ok;
  logic rule_ok;
  logic param_ok;

  // codes beyond CLASS_N-1 match no enable bit
  always_comb begin
    cls_ok = 1'b0;
    for (int k = 0; k < CLASS_N; k++) begin
      if (class_i == CLS_W'(k)) cls_ok = en_i[k];
    end
  end

  assign rule_ok  = |(rule_hit_i & ~rmask_i);
  assign param_ok = |(param_hit_i & ~pmask_i);
  assign qual_o   = evt_i && cls_ok && rule_ok && param_ok;
endmodule

// File: rtl/ts_capture.sv
module ts_capture #(
  parameter int TS_W  = 64,
  parameter int SEQ_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             qual_i,
  input  logic             rearm_i,
  input  logic [TS_W-1:0]  time_i,
  input  logic [SEQ_W-1:0] seq_i,
  output logic             valid_o,
  output logic [TS_W-1:0]  ts_o,
  output logic [SEQ_W-1:0] seq_o
);
  // locked: only rearm acts; open: only a qualifying event acts
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      ts_o    <= '0;
      seq_o   <= '0;
    end else if (valid_o) begin
      if (rearm_i) valid_o <= 1'b0;
    end else if (qual_i) begin
      valid_o <= 1'b1;
      ts_o    <= time_i;
      seq_o   <= seq_i;
    end
  end
endmodule

// File: rtl/ts_capture_latch.sv
module ts_capture_latch
  import ts_latch_pkg::*;
#(
  parameter int P_TS_W    = TS_W,
  parameter int P_RULE_W  = RULE_W,
  parameter int P_PARAM_W = PARAM_W,
  parameter int P_SEQ_W   = SEQ_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [P_TS_W-1:0]    time_i,
  input  logic                 rx_evt_i,
  input  logic [CLS_W-1:0]     rx_class_i,
  input  logic [P_RULE_W-1:0]  rx_rule_hit_i,
  input  logic [P_PARAM_W-1:0] rx_param_hit_i,
  input  logic [P_SEQ_W-1:0]   rx_seq_i,
  input  logic                 tx_evt_i,
  input  logic [CLS_W-1:0]     tx_class_i,
  input  logic [P_RULE_W-1:0]  tx_rule_hit_i,
  input  logic [P_PARAM_W-1:0] tx_param_hit_i,
  input  logic [P_SEQ_W-1:0]   tx_seq_i,
  input  logic                 reg_we_i,
  input  logic [ADDR_W-1:0]    reg_waddr_i,
  input  logic [WORD_W-1:0]    reg_wdata_i,
  input  logic [ADDR_W-1:0]    reg_raddr_i,
  output logic [WORD_W-1:0]    reg_rdata_o
);
  localparam int VBIT = P_SEQ_W;

  logic [DIR_N-1:0]                evt_a;
  logic [DIR_N-1:0][CLS_W-1:0]     cls_a;
  logic [DIR_N-1:0][P_RULE_W-1:0]  rhit_a;
  logic [DIR_N-1:0][P_PARAM_W-1:0] phit_a;
  logic [DIR_N-1:0][P_SEQ_W-1:0]   seqin_a;

  logic [DIR_N-1:0]                qual_w;
  logic [DIR_N-1:0]                rearm_w;
  logic [DIR_N-1:0]                valid_w;
  logic [DIR_N-1:0][P_TS_W-1:0]    ts_w;
  logic [DIR_N-1:0][P_SEQ_W-1:0]   seq_w;
  logic [DIR_N-1:0][CLASS_N-1:0]   en_w;
  logic [DIR_N-1:0][P_RULE_W-1:0]  rmask_w;
  logic [DIR_N-1:0][P_PARAM_W-1:0] pmask_w;

  logic [OFF_W-1:0] woff;
  logic [OFF_W-1:0] roff;
  logic             rdir;

  assign evt_a   = {tx_evt_i, rx_evt_i};
  assign cls_a   = {tx_class_i, rx_class_i};
  assign rhit_a  = {tx_rule_hit_i, rx_rule_hit_i};
  assign phit_a  = {tx_param_hit_i, rx_param_hit_i};
  assign seqin_a = {tx_seq_i, rx_seq_i};

  assign woff = reg_waddr_i[OFF_W-1:0];
  assign roff = reg_raddr_i[OFF_W-1:0];
  assign rdir = reg_raddr_i[ADDR_W-1];

  for (genvar d = 0; d < DIR_N; d++) begin : g_dir
    logic wsel;
    assign wsel       = reg_we_i && (reg_waddr_i[ADDR_W-1] == 1'(d));
    assign rearm_w[d] = wsel && (woff == OFF_STATUS) && reg_wdata_i[VBIT];

    ts_cfg_regs #(
      .CLASS_N(CLASS_N), .RULE_W(P_RULE_W), .PARAM_W(P_PARAM_W)
    ) u_cfg (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .we_en_i    (wsel && (woff == OFF_EN)),
      .we_rmask_i (wsel && (woff == OFF_RMASK)),
      .we_pmask_i (wsel && (woff == OFF_PMASK)),
      .en_d_i     (reg_wdata_i[CLASS_N-1:0]),
      .rmask_d_i  (reg_wdata_i[P_RULE_W-1:0]),
      .pmask_d_i  (reg_wdata_i[P_PARAM_W-1:0]),
      .en_o       (en_w[d]),
      .rmask_o    (rmask_w[d]),
      .pmask_o    (pmask_w[d])
    );

    ts_qualify #(
      .CLASS_N(CLASS_N), .CLS_W(CLS_W), .RULE_W(P_RULE_W), .PARAM_W(P_PARAM_W)
    ) u_qual (
      .evt_i       (evt_a[d]),
      .class_i     (cls_a[d]),
      .rule_hit_i  (rhit_a[d]),
      .param_hit_i (phit_a[d]),
      .en_i        (en_w[d]),
      .rmask_i     (rmask_w[d]),
      .pmask_i     (pmask_w[d]),
      .qual_o      (qual_w[d])
    );

    ts_capture #(
      .TS_W(P_TS_W), .SEQ_W(P_SEQ_W)
    ) u_cap (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .qual_i  (qual_w[d]),
      .rearm_i (rearm_w[d]),
      .time_i  (time_i),
      .seq_i   (seqin_a[d]),
      .valid_o (valid_w[d]),
      .ts_o    (ts_w[d]),
      .seq_o   (seq_w[d])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (roff)
      OFF_STATUS: reg_rdata_o = WORD_W'({valid_w[rdir], seq_w[rdir]});
      OFF_TS_LO:  reg_rdata_o = ts_w[rdir][WORD_W-1:0];
      OFF_TS_HI:  reg_rdata_o = WORD_W'(ts_w[rdir] >> WORD_W);
      OFF_EN:     reg_rdata_o = WORD_W'(en_w[rdir]);
      OFF_RMASK:  reg_rdata_o = WORD_W'(rmask_w[rdir]);
      OFF_PMASK:  reg_rdata_o = WORD_W'(pmask_w[rdir]);
      default:    reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ts_capture_latch_chk.sv
module ts_capture_latch_chk #(
  parameter int DIR_N = 2,
  parameter int TS_W  = 64
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [TS_W-1:0]             time_i,
  input logic [DIR_N-1:0]            qual_i,
  input logic [DIR_N-1:0]            rearm_i,
  input logic [DIR_N-1:0]            valid_i,
  input logic [DIR_N-1:0][TS_W-1:0]  ts_i
);
  for (genvar d = 0; d < DIR_N; d++) begin : g_chk
    a_r3_capture_time: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (qual_i[d] && !valid_i[d]) |=> (valid_i[d] && ts_i[d] == $past(time_i)));

    a_r4_set_needs_qual: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!valid_i[d] && !qual_i[d]) |=> !valid_i[d]);

    a_r6_hold_ts: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i[d] |=> $stable(ts_i[d]));

    a_r7_rearm_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rearm_i[d] && valid_i[d]) |=> !valid_i[d]);

    a_r6_stay_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i[d] && !rearm_i[d]) |=> valid_i[d]);

    a_r8_collision_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i[d] && rearm_i[d] && qual_i[d]) |=> (!valid_i[d] && $stable(ts_i[d])));
  end
endmodule

bind ts_capture_latch ts_capture_latch_chk #(
  .DIR_N(ts_latch_pkg::DIR_N), .TS_W(P_TS_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .time_i  (time_i),
  .qual_i  (qual_w),
  .rearm_i (rearm_w),
  .valid_i (valid_w),
  .ts_i    (ts_w)
);

// File: tb/tb_ts_capture_latch.sv
module tb_ts_capture_latch;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [63:0] time_v = 64'h0000_0001_0000_0000;
  bit          s_evt [2];
  bit [1:0]    s_cls [2];
  bit [13:0]   s_rh  [2];
  bit [10:0]   s_ph  [2];
  bit [15:0]   s_seq [2];
  logic        we = 1'b0;
  logic [3:0]  waddr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  raddr = '0;
  logic [31:0] rdata;

  ts_capture_latch dut (
    .clk_i(clk), .rst_ni(rst_n), .time_i(time_v),
    .rx_evt_i(s_evt[0]), .rx_class_i(s_cls[0]), .rx_rule_hit_i(s_rh[0]),
    .rx_param_hit_i(s_ph[0]), .rx_seq_i(s_seq[0]),
    .tx_evt_i(s_evt[1]), .tx_class_i(s_cls[1]), .tx_rule_hit_i(s_rh[1]),
    .tx_param_hit_i(s_ph[1]), .tx_seq_i(s_seq[1]),
    .reg_we_i(we), .reg_waddr_i(waddr), .reg_wdata_i(wdata),
    .reg_raddr_i(raddr), .reg_rdata_o(rdata)
  );

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  // behavioural reference
  bit              m_valid [2];
  longint unsigned m_ts    [2];
  int unsigned     m_seq   [2];
  int unsigned     m_en    [2];
  int unsigned     m_rm    [2];
  int unsigned     m_pm    [2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int d = 0; d < 2; d++) begin
        m_valid[d] = 0; m_ts[d] = 0; m_seq[d] = 0;
        m_en[d] = 0; m_rm[d] = 'h3FFF; m_pm[d] = 'h7FF;
      end
    end else begin
      for (int d = 0; d < 2; d++) begin
        bit q;
        bit rearm;
        q = s_evt[d] && (s_cls[d] < 3) && (((m_en[d] >> s_cls[d]) & 1) == 1)
            && ((s_rh[d] & ~m_rm[d][13:0]) != 0) && ((s_ph[d] & ~m_pm[d][10:0]) != 0);
        rearm = we && (waddr[3] == d[0]) && (waddr[2:0] == 0) && wdata[16];
        if (m_valid[d]) begin
          if (rearm) m_valid[d] = 0;
        end else if (q) begin
          m_valid[d] = 1; m_ts[d] = time_v; m_seq[d] = s_seq[d];
        end
      end
      if (we) begin
        case (waddr[2:0])
          3: m_en[waddr[3]] = wdata & 'h7;
          4: m_rm[waddr[3]] = wdata & 'h3FFF;
          5: m_pm[waddr[3]] = wdata & 'h7FF;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] exp_read(input logic [3:0] a);
    int d;
    d = a[3];
    case (a[2:0])
      0: return {15'd0, m_valid[d], m_seq[d][15:0]};
      1: return m_ts[d][31:0];
      2: return m_ts[d][63:32];
      3: return m_en[d];
      4: return m_rm[d];
      5: return m_pm[d];
      default: return 32'd0;
    endcase
  endfunction

  // one clock: stimulus set by caller is taken at the edge, then one read-back
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    for (int d = 0; d < 2; d++) s_evt[d] = 0;
    we = 0;
    time_v = time_v + 64'h0000_0001_0000_0007;
    raddr = raddr + 4'd1;
    #1;
    n_cmp++;
    if (rdata !== exp_read(raddr)) begin
      n_bad++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", cur_req, raddr, rdata, exp_read(raddr));
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic set_wr(input bit d, input bit [2:0] off, input logic [31:0] v);
    we = 1; waddr = {d, off}; wdata = v;
  endtask

  task automatic set_ev(input bit d, input bit [1:0] c, input bit [13:0] rh,
                        input bit [10:0] ph, input bit [15:0] sq);
    s_evt[d] = 1; s_cls[d] = c; s_rh[d] = rh; s_ph[d] = ph; s_seq[d] = sq;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values on every address
    cur_req = "R1"; idle(16);
    // R4 default all-ones masks block even with every class enabled
    cur_req = "R4";
    set_wr(0, 3, 32'h7); step();
    set_ev(0, 0, 14'h3FFF, 11'h7FF, 16'h0101); step(); idle(16);
    // R3 capture after opening masks
    cur_req = "R3";
    set_wr(0, 4, 32'h0); step();
    set_wr(0, 5, 32'h0); step();
    set_ev(0, 0, 14'h0001, 11'h001, 16'h1234); step(); idle(16);
    // R6 later events ignored
    cur_req = "R6";
    set_ev(0, 1, 14'h3FFF, 11'h7FF, 16'hBEEF); step(); idle(16);
    // R7 rearm only with bit 16
    cur_req = "R7";
    set_wr(0, 0, 32'h0000_FFFF); step(); idle(16);
    set_wr(0, 0, 32'h0001_0000); step(); idle(16);
    set_ev(0, 2, 14'h0100, 11'h010, 16'h2222); step(); idle(4);
    // R8 collision while locked: event dropped
    cur_req = "R8";
    set_wr(0, 0, 32'h0001_0000); set_ev(0, 0, 14'h1, 11'h1, 16'h3333); step(); idle(16);
    // R8 collision while open: event captured
    set_wr(0, 0, 32'hFFFF_FFFF); set_ev(0, 0, 14'h1, 11'h1, 16'h4444); step(); idle(16);
    // R4 individual mask bits
    cur_req = "R4";
    set_wr(0, 0, 32'h0001_0000); step();
    set_wr(0, 4, 32'h3FFE); step();
    set_ev(0, 0, 14'h0001, 11'h1, 16'h5555); step(); idle(16);
    set_ev(0, 0, 14'h2001, 11'h1, 16'h5556); step(); idle(16);
    set_wr(0, 0, 32'h0001_0000); step();
    set_wr(0, 5, 32'h7FE); step();
    set_ev(0, 0, 14'h2000, 11'h001, 16'h5557); step(); idle(16);
    set_ev(0, 0, 14'h2000, 11'h400, 16'h5558); step(); idle(16);
    // R5 class enables
    cur_req = "R5";
    set_wr(0, 0, 32'h0001_0000); step();
    set_wr(0, 3, 32'h2); step();
    set_ev(0, 0, 14'h2000, 11'h400, 16'h6660); step(); idle(8);
    set_ev(0, 3, 14'h2000, 11'h400, 16'h6663); step(); idle(8);
    set_ev(0, 2, 14'h2000, 11'h400, 16'h6662); step(); idle(8);
    set_ev(0, 1, 14'h2000, 11'h400, 16'h6661); step(); idle(16);
    set_wr(0, 0, 32'h0001_0000); step();
    set_wr(0, 3, 32'h0); step();
    set_ev(0, 1, 14'h3FFF, 11'h7FF, 16'h6664); step(); idle(16);
    // R9 transmit path alone, receive untouched
    cur_req = "R9";
    set_wr(0, 3, 32'h7); step();
    set_ev(0, 0, 14'h2000, 11'h400, 16'h7000); step();
    set_wr(1, 3, 32'h4); step();
    set_wr(1, 4, 32'h0); step();
    set_wr(1, 5, 32'h0); step();
    set_ev(1, 2, 14'h0002, 11'h002, 16'h7001); step(); idle(16);
    set_wr(1, 0, 32'h0001_0000); step(); idle(16);
    set_ev(1, 2, 14'h0002, 11'h002, 16'h7002); set_ev(0, 0, 14'h2000, 11'h400, 16'h7003); step(); idle(16);
    // R2 read-only and unused offsets
    cur_req = "R2";
    set_wr(0, 1, 32'hFFFF_FFFF); step();
    set_wr(0, 2, 32'hFFFF_FFFF); step();
    set_wr(1, 6, 32'hFFFF_FFFF); step();
    set_wr(1, 7, 32'hFFFF_FFFF); step();
    set_wr(0, 3, 32'hFFFF_FFF8); step(); idle(16);
    // R10 random traffic on both paths
    cur_req = "R10";
    for (int i = 0; i < 4000; i++) begin
      for (int d = 0; d < 2; d++) begin
        if ($urandom_range(0, 2) == 0)
          set_ev(d[0], 2'($urandom_range(0, 3)), 14'(1 << $urandom_range(0, 13)),
                 11'(1 << $urandom_range(0, 10)), 16'($urandom));
      end
      case ($urandom_range(0, 15))
        0, 1, 2: set_wr(1'($urandom_range(0, 1)), 0, $urandom);
        3: set_wr(1'($urandom_range(0, 1)), 3, $urandom);
        4: set_wr(1'($urandom_range(0, 1)), 4, $urandom & 32'hFFFF_3FF0);
        5: set_wr(1'($urandom_range(0, 1)), 5, $urandom & 32'hFFFF_FCF0);
        default: ;
      endcase
      step();
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule